// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block folds many level-sensitive interrupt lines into a smaller set of requests for a parent interrupt controller. Sources are arranged in combiners of eight. Each combiner drives one request line, which is high while at least one of its enabled sources is high. After reset every source is masked.

Four neighbouring combiners share one 32-bit register set, and each combiner owns one byte lane of it. Software changes enables only through two registers. Writing a one to the set register enables a source. Writing a one to the clear register masks it. A zero bit leaves that enable as it was. A read-only status register returns the raw inputs ANDed with their enables, so a handler can find which source of a group is active. The number of combiners is a parameter. The default is 16, and a larger variant uses 32.

Top module: `irq_combiner_bank`

## Requirements
- R1: After reset every enable bit is 0, every combined output is 0 and the read data is 0.
- R2: A write to offset 0x0 of a group's register set enables each source whose data bit is 1. Sources whose data bit is 0 keep their enable state.
- R3: A write to offset 0x4 of a group's register set masks each source whose data bit is 1. Sources whose data bit is 0 keep their enable state.
- R4: Combiner n owns the register set at base (n/4)*0x10 and the byte lane (n mod 4)*8 of it. Source k of combiner n sits at bit (n*8+k) mod 32 of that set.
- R5: A read of offset 0x0 or 0x4 returns the group's current enable bits. A read of offset 0x8 returns the raw inputs ANDed with those enables. Read data appears on the cycle after the read strobe and holds until the next read.
- R6: Combined output n goes high one clock after any enabled source of combiner n is high. It stays high while such a source stays high. It goes low one clock after none is.
- R7: Writes to a group beyond the configured count, or to an offset other than 0x0 and 0x4, change no enable. Reads from such addresses return 0.
- R8: The status register at offset 0x8 is read-only. A write to it changes no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_COMB*8 | Level interrupt sources, flat index combiner*8+source |
| comb_o | output | NUM_COMB | Registered combined request per combiner |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume that the read and write strobes are never both high on the same cycle. They also assume that the address and write data stay steady through the edge where a strobe is sampled. The bench drives every input on the falling edge, one bus operation per task call, and never overlaps a read with a write. Source levels change only between bus operations, so each check of a combined output sees a single cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned LANES     = 4;
   localparam int unsigned LANE_W    = 8;
   localparam int unsigned REG_W     = LANES * LANE_W;
   localparam int unsigned STRIDE_LG = 4;

   typedef enum logic [1:0] {
      SEL_SET  = 2'd0,
      SEL_CLR  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   function automatic reg_sel_e offset_to_sel(input logic [STRIDE_LG-1:0] off);
      case (off)
         4'h0:    return SEL_SET;
         4'h4:    return SEL_CLR;
         4'h8:    return SEL_STAT;
         default: return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_GRP = 4,
   parameter int unsigned ADDR_W  = 8,
   localparam int unsigned GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
   localparam int unsigned UP_W   = ADDR_W - STRIDE_LG
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   addr_i,
   output logic [GIDX_W-1:0]   grp_idx_o,
   output logic [NUM_GRP-1:0]  grp_hit_o,
   output reg_sel_e            sel_o,
   output logic                hit_o
);
   logic [UP_W-1:0]      upper;
   logic [STRIDE_LG-1:0] offset;
   logic                 in_range;

   assign upper     = addr_i[ADDR_W-1:STRIDE_LG];
   assign offset    = addr_i[STRIDE_LG-1:0];
   assign in_range  = ({{(32-UP_W){1'b0}}, upper} < 32'(NUM_GRP));
   assign sel_o     = offset_to_sel(offset);
   assign hit_o     = in_range && (sel_o != SEL_NONE);
   assign grp_idx_o = upper[GIDX_W-1:0];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_hit
      assign grp_hit_o[g] = hit_o && (upper == UP_W'(g));
   end

   // R4: at most one register set answers any address
   a_r4_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grp_hit_o));
endmodule

// File: rtl/irqc_group.sv
module irqc_group
   import irqc_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [REG_W-1:0] src_i,
   input  logic             set_we_i,
   input  logic             clr_we_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] en_o,
   output logic [REG_W-1:0] status_o,
   output logic [LANES-1:0] comb_o
);
   logic [REG_W-1:0] en_q;
   logic [LANES-1:0] comb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (set_we_i) begin
         en_q <= en_q | wdata_i;
      end else if (clr_we_i) begin
         en_q <= en_q & ~wdata_i;
      end
   end

   assign status_o = src_i & en_q;
   assign en_o     = en_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) comb_q[l] <= 1'b0;
         else         comb_q[l] <= |status_o[l*LANE_W +: LANE_W];
      end

      // R6: a lane with no enabled source cannot request on the next cycle
      a_r6_masked_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en_q[l*LANE_W +: LANE_W] == '0) |=> !comb_q[l]);
   end

   assign comb_o = comb_q;

   // R2: every bit written as one is enabled afterwards
   a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_we_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
   // R3: every bit written as one is masked afterwards
   a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && !set_we_i) |=> ((en_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irq_combiner_bank.sv
module irq_combiner_bank
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_COMB = 16,
   parameter int unsigned ADDR_W   = 8,
   localparam int unsigned NUM_SRC = NUM_COMB * LANE_W,
   localparam int unsigned NUM_GRP = NUM_COMB / LANES,
   localparam int unsigned GIDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_SRC-1:0]  src_i,
   output logic [NUM_COMB-1:0] comb_o,
   input  logic                bus_wr_i,
   input  logic                bus_rd_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [REG_W-1:0]    bus_wdata_i,
   output logic [REG_W-1:0]    bus_rdata_o
);
   if (NUM_COMB == 0 || (NUM_COMB % LANES) != 0) begin : g_bad_count
      $error("NUM_COMB must be a nonzero multiple of four");
   end
   if (ADDR_W < STRIDE_LG + GIDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the number of register sets");
   end

   logic [GIDX_W-1:0]  grp_idx;
   logic [NUM_GRP-1:0] grp_hit;
   reg_sel_e           sel;
   logic               hit;

   irqc_decode #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_dec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_i    (bus_addr_i),
      .grp_idx_o (grp_idx),
      .grp_hit_o (grp_hit),
      .sel_o     (sel),
      .hit_o     (hit)
   );

   logic [REG_W-1:0] en_grp   [NUM_GRP];
   logic [REG_W-1:0] stat_grp [NUM_GRP];
   logic [NUM_SRC-1:0] en_all;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic set_we, clr_we;
      assign set_we = bus_wr_i && grp_hit[g] && (sel == SEL_SET);
      assign clr_we = bus_wr_i && grp_hit[g] && (sel == SEL_CLR);

      irqc_group u_grp (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .src_i    (src_i[g*REG_W +: REG_W]),
         .set_we_i (set_we),
         .clr_we_i (clr_we),
         .wdata_i  (bus_wdata_i),
         .en_o     (en_grp[g]),
         .status_o (stat_grp[g]),
         .comb_o   (comb_o[g*LANES +: LANES])
      );
      assign en_all[g*REG_W +: REG_W] = en_grp[g];
   end

   logic [REG_W-1:0] rd_word;
   logic [REG_W-1:0] rdata_q;

   always_comb begin
      rd_word = '0;
      if (hit) begin
         case (sel)
            SEL_SET, SEL_CLR: rd_word = en_grp[grp_idx];
            SEL_STAT:         rd_word = stat_grp[grp_idx];
            default:          rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_word;
   end

   assign bus_rdata_o = rdata_q;

   // R7: unmapped reads return zero
   a_r7_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && !hit) |=> (bus_rdata_o == '0));
   // R7: unmapped writes leave every enable untouched
   a_r7_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && !hit) |=> $stable(en_all));
   // R8: the status register ignores writes
   a_r8_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && hit && (sel == SEL_STAT)) |=> $stable(en_all));
   // R5: read data only moves on a read
   a_r5_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/irq_combiner_bank_tb.sv
`timescale 1ns/1ps
module irq_combiner_bank_tb;
   localparam int NC = 16;
   localparam int NS = NC * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic [NC-1:0] comb;
   logic          wr = 1'b0, rd = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0, rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [31:0] exp_en [4];

   always #2.5 clk = ~clk;

   irq_combiner_bank #(.NUM_COMB(NC), .ADDR_W(8)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .comb_o(comb),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 comb", 32'(comb), 32'h0);
      check("R1 rdata", rdata, 32'h0);
      for (int g = 0; g < 4; g++) begin
         bus_read(8'(g * 16), v);
         check("R1 enable", v, 32'h0);
      end
   endtask

   task automatic t_set_clear();
      logic [31:0] v;
      bus_write(8'h00, 32'h0000_00A5); exp_en[0] = 32'h0000_00A5;
      bus_read(8'h00, v);  check("R2 set", v, exp_en[0]);
      bus_write(8'h00, 32'h0000_0100); exp_en[0] = 32'h0000_01A5;
      bus_read(8'h00, v);  check("R2 zeros keep", v, exp_en[0]);
      bus_write(8'h04, 32'h0000_0005); exp_en[0] = 32'h0000_01A0;
      bus_read(8'h04, v);  check("R3 clear via R5 read", v, exp_en[0]);
   endtask

   task automatic t_lane_map();
      logic [31:0] v;
      // combiner 6 source 3: flat 51 -> set 0x10, bit 19 (R4)
      bus_write(8'h10, 32'h0008_0000); exp_en[1] = 32'h0008_0000;
      @(negedge clk);
      src[51] = 1'b1; src[50] = 1'b1;
      @(negedge clk);
      check("R4 R6 comb6", 32'(comb), 32'h0040);
      bus_read(8'h18, v); check("R5 status", v, 32'h0008_0000);
      // enable source 2 too; drop source 3, OR keeps it high (R6)
      bus_write(8'h10, 32'h0004_0000); exp_en[1] = 32'h000C_0000;
      @(negedge clk); src[51] = 1'b0;
      @(negedge clk);
      check("R6 or hold", 32'(comb), 32'h0040);
      bus_read(8'h18, v); check("R5 status2", v, 32'h0004_0000);
      src[50] = 1'b0;
      @(negedge clk);
      check("R6 fall", 32'(comb), 32'h0000);
      src[51] = 1'b1;
      @(negedge clk);
      check("R6 rise again", 32'(comb), 32'h0040);
      bus_write(8'h14, 32'h000C_0000); exp_en[1] = 32'h0;
      @(negedge clk);
      check("R3 mask drops comb", 32'(comb), 32'h0000);
      src = '0;
   endtask

   task automatic t_top_lane();
      // combiner 15 source 7: flat 127 -> set 0x30, bit 31 (R4)
      bus_write(8'h30, 32'h8000_0000); exp_en[3] = 32'h8000_0000;
      @(negedge clk); src[127] = 1'b1; src[0] = 1'b1;
      @(negedge clk);
      check("R4 comb15", 32'(comb), 32'h8000);
      src[5] = 1'b1;
      @(negedge clk);
      check("R4 comb0 lane", 32'(comb), 32'h8001);
      src = '0;
      @(negedge clk);
      check("R6 all low", 32'(comb), 32'h0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus_write(8'h40, 32'hFFFF_FFFF);
      bus_write(8'h0C, 32'hFFFF_FFFF);
      bus_write(8'h02, 32'hFFFF_FFFF);
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_read(8'h40, v); check("R7 read beyond", v, 32'h0);
      bus_read(8'h0C, v); check("R7 read hole", v, 32'h0);
      for (int g = 0; g < 4; g++) begin
         bus_read(8'(g * 16), v);
         check("R7 R8 enables kept", v, exp_en[g]);
      end
      @(negedge clk); src = '1;
      @(negedge clk);
      check("R7 R8 comb pattern", 32'(comb), 32'h8003);
      bus_read(8'h08, v); check("R5 status full", v, exp_en[0]);
      src = '0;
   endtask

   initial begin
      for (int g = 0; g < 4; g++) exp_en[g] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_set_clear();
      t_lane_map();
      t_top_lane();
      t_unmapped();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule